// File: doc/BRIEF.md
# DMA Major-Loop Iteration and Linking Sequencer

This block keeps the major-loop bookkeeping for every channel of a multi-channel DMA engine. Each channel has a slot that holds a current iteration count, a beginning iteration count, a control byte and a signed last-destination adjustment. When a data mover reports that a channel finished a minor loop, the sequencer decrements that channel's current count and writes it back. It may also ask another channel to start through a minor-loop link.

When the decrement reaches zero, the major loop is finished. The sequencer then reloads the count from the beginning value and either adjusts the destination address or, in scatter/gather mode, hands the adjustment word out as the address of the next descriptor. It can also raise a completion interrupt and start a major-loop link target.

The count register has two layouts, selected by its top bit. When that bit is set, a link channel number shares the register with a narrower count. A slot whose layout bits disagree, or whose count is zero, is flagged as misconfigured and does not run.

Top module: `dma_iter_seq`

## Requirements
- R1: After reset every slot register reads zero, every bit of `cfg_err` is 1, and `start_req`, `done_irq`, `adj_valid` and `sg_load` are 0.
- R2: Slot register writes use `wr_sel` 0 = current count, 1 = beginning count, 2 = control, 3 = adjustment. In a count word, bit 15 set means linked layout: bits 12:9 hold the link channel and bits 8:0 hold the count. Bit 15 clear means the count is in bits 14:0. A minor-loop completion that does not end the major loop lowers the count by one and leaves bit 15 and the link field unchanged. `rd_cur` shows the new value in the cycle after the completion.
- R3: A non-final completion on a channel in linked layout raises `start_req` for the link channel in the cycle after the completion.
- R4: When a completion takes the count to zero, no minor-loop link is issued and the current count is reloaded with the whole beginning-count word.
- R5: Control bit 2 enables a major-loop link to the channel in control bits 7:4. That request is raised only on the completion that ends the major loop.
- R6: Control bit 0 enables a one-cycle `done_irq` pulse for the channel on the completion that ends the major loop. With bit 0 clear, no pulse is raised.
- R7: On the completion that ends the major loop, `adj_valid` pulses for one cycle. With control bit 1 clear, `adj_addr` equals `minor_dst` plus the adjustment value (two's complement) and `sg_load` is 0. With bit 1 set, `adj_addr` equals the adjustment value and `sg_load` is 1.
- R8: `cfg_err` for a channel is 1 when bit 15 differs between its current and beginning counts, or when either count field is zero. A completion on such a channel changes nothing and produces no output.
- R9: A software start and a link request aimed at the same channel in the same cycle give one `start_req` bit. A channel may link to itself. No `start_req` bit is raised without a start or link cause.
- R10: A software write to a current count in the same cycle as a completion on that channel takes precedence over the decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| minor_done | input | 1 | Minor-loop completion pulse |
| minor_ch | input | 4 | Channel that completed its minor loop |
| minor_dst | input | 32 | Channel's destination address at completion |
| sw_start | input | 1 | Software start request |
| sw_ch | input | 4 | Channel for software start |
| wr_en | input | 1 | Slot register write strobe |
| wr_ch | input | 4 | Slot to write |
| wr_sel | input | 2 | Register select within the slot |
| wr_data | input | 32 | Write data |
| rd_ch | input | 4 | Slot whose current count is shown |
| rd_cur | output | 16 | Current count word of slot `rd_ch` |
| cfg_err | output | 16 | Per-channel configuration error |
| start_req | output | 16 | Per-channel start request pulse |
| done_irq | output | 16 | Per-channel major-loop completion interrupt pulse |
| adj_valid | output | 1 | Final address result valid |
| adj_addr | output | 32 | Adjusted destination or next-descriptor address |
| sg_load | output | 1 | `adj_addr` is a descriptor address to fetch |

## Verification
The assertions assume that `minor_done` and `sw_start` are single-cycle strobes, and that channel numbers on the inputs always name an existing slot. They also assume completions arrive only for channels that software configured. The bench drives every strobe for exactly one cycle on the falling edge and uses only channels 0 to 15. It programs each slot fully, with equal current and beginning counts, before reporting completions. The only exceptions are the deliberate configuration-error cases, and for those the assertions require the completion to have no effect.

// File: rtl/dma_iter_pkg.sv
package dma_iter_pkg;
  localparam int CNT_REG_W  = 16;
  localparam int CNT_FULL_W = 15;
  localparam int CNT_LNK_W  = 9;
  localparam int LNK_LSB    = 9;
  localparam int LNK_W      = 4;
  localparam int LAYOUT_BIT = 15;
  localparam int CTRL_W     = 8;
  localparam int CTL_IRQ    = 0;
  localparam int CTL_SG     = 1;
  localparam int CTL_MLINK  = 2;
  localparam int CTL_MCH    = 4;

  typedef enum logic [1:0] {
    SEL_CUR   = 2'd0,
    SEL_BEG   = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_ADJ   = 2'd3
  } slot_sel_e;

  function automatic logic [CNT_FULL_W-1:0] count_of(input logic [CNT_REG_W-1:0] w);
    if (w[LAYOUT_BIT]) count_of = {{(CNT_FULL_W-CNT_LNK_W){1'b0}}, w[CNT_LNK_W-1:0]};
    else               count_of = w[CNT_FULL_W-1:0];
  endfunction
endpackage

// File: rtl/dma_iter_slot.sv
module dma_iter_slot
  import dma_iter_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [1:0]           wr_sel,
  input  logic [AW-1:0]        wr_data,
  input  logic                 upd_en,
  input  logic [CNT_REG_W-1:0] upd_cur,
  output logic [CNT_REG_W-1:0] cur_o,
  output logic [CNT_REG_W-1:0] beg_o,
  output logic [CTRL_W-1:0]    ctrl_o,
  output logic [AW-1:0]        adj_o,
  output logic                 cfg_err_o
);
  logic [CNT_REG_W-1:0] cur_q, cur_d, beg_q, beg_d;
  logic [CTRL_W-1:0]    ctrl_q, ctrl_d;
  logic [AW-1:0]        adj_q, adj_d;

  always_comb begin
    cur_d  = cur_q;
    beg_d  = beg_q;
    ctrl_d = ctrl_q;
    adj_d  = adj_q;
    if (upd_en) cur_d = upd_cur;
    if (wr_en) begin
      case (slot_sel_e'(wr_sel))
        SEL_CUR:  cur_d  = wr_data[CNT_REG_W-1:0];
        SEL_BEG:  beg_d  = wr_data[CNT_REG_W-1:0];
        SEL_CTRL: ctrl_d = wr_data[CTRL_W-1:0];
        default:  adj_d  = wr_data;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      beg_q  <= '0;
      ctrl_q <= '0;
      adj_q  <= '0;
    end else if (wr_en || upd_en) begin
      cur_q  <= cur_d;
      beg_q  <= beg_d;
      ctrl_q <= ctrl_d;
      adj_q  <= adj_d;
    end
  end

  assign cur_o     = cur_q;
  assign beg_o     = beg_q;
  assign ctrl_o    = ctrl_q;
  assign adj_o     = adj_q;
  assign cfg_err_o = (cur_q[LAYOUT_BIT] != beg_q[LAYOUT_BIT])
                   || (count_of(cur_q) == '0) || (count_of(beg_q) == '0);
endmodule

// File: rtl/dma_iter_step.sv
module dma_iter_step
  import dma_iter_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic                 act,
  input  logic [CNT_REG_W-1:0] cur,
  input  logic [CNT_REG_W-1:0] beg,
  input  logic [CTRL_W-1:0]    ctrl,
  input  logic [AW-1:0]        adj,
  input  logic [AW-1:0]        dst,
  output logic                 upd_en,
  output logic [CNT_REG_W-1:0] upd_cur,
  output logic                 exhaust,
  output logic                 mnr_vld,
  output logic [LNK_W-1:0]     mnr_ch,
  output logic                 mjr_vld,
  output logic [LNK_W-1:0]     mjr_ch,
  output logic                 irq,
  output logic                 sg,
  output logic [AW-1:0]        adj_addr
);
  logic [CNT_FULL_W-1:0] cnt, nxt;

  always_comb begin
    cnt     = count_of(cur);
    nxt     = cnt - 1'b1;
    upd_en  = act;
    exhaust = act && (nxt == '0);
    if (exhaust)               upd_cur = beg;
    else if (cur[LAYOUT_BIT])  upd_cur = {cur[CNT_REG_W-1:CNT_LNK_W], nxt[CNT_LNK_W-1:0]};
    else                       upd_cur = {cur[LAYOUT_BIT], nxt};
    mnr_vld  = act && !exhaust && cur[LAYOUT_BIT];
    mnr_ch   = cur[LNK_LSB +: LNK_W];
    mjr_vld  = exhaust && ctrl[CTL_MLINK];
    mjr_ch   = ctrl[CTL_MCH +: LNK_W];
    irq      = exhaust && ctrl[CTL_IRQ];
    sg       = ctrl[CTL_SG];
    adj_addr = sg ? adj : (dst + adj);
  end
endmodule

// File: rtl/dma_iter_out.sv
module dma_iter_out
  import dma_iter_pkg::*;
#(
  parameter int NCH = 16,
  parameter int AW  = 32,
  localparam int CHW = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_start,
  input  logic [CHW-1:0]   sw_ch,
  input  logic             mnr_vld,
  input  logic [LNK_W-1:0] mnr_ch,
  input  logic             mjr_vld,
  input  logic [LNK_W-1:0] mjr_ch,
  input  logic             exhaust,
  input  logic             irq,
  input  logic [CHW-1:0]   irq_ch,
  input  logic             sg,
  input  logic [AW-1:0]    adj_addr_d,
  output logic [NCH-1:0]   start_req,
  output logic [NCH-1:0]   done_irq,
  output logic             adj_valid,
  output logic [AW-1:0]    adj_addr,
  output logic             sg_load
);
  logic [NCH-1:0] start_d, irq_d, start_q, irq_q;
  logic           vld_q, sg_q;
  logic [AW-1:0]  addr_q;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      start_d[i] = (sw_start && (sw_ch == CHW'(i)))
                || (mnr_vld && (mnr_ch == LNK_W'(i)))
                || (mjr_vld && (mjr_ch == LNK_W'(i)));
      irq_d[i]   = irq && (irq_ch == CHW'(i));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      irq_q   <= '0;
      vld_q   <= 1'b0;
      sg_q    <= 1'b0;
    end else begin
      start_q <= start_d;
      irq_q   <= irq_d;
      vld_q   <= exhaust;
      sg_q    <= exhaust && sg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (exhaust) addr_q <= adj_addr_d;
  end

  assign start_req = start_q;
  assign done_irq  = irq_q;
  assign adj_valid = vld_q;
  assign adj_addr  = addr_q;
  assign sg_load   = sg_q;
endmodule

// File: rtl/dma_iter_seq.sv
module dma_iter_seq
  import dma_iter_pkg::*;
#(
  parameter int NCH = 16,
  parameter int AW  = 32,
  localparam int CHW = $clog2(NCH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 minor_done,
  input  logic [CHW-1:0]       minor_ch,
  input  logic [AW-1:0]        minor_dst,
  input  logic                 sw_start,
  input  logic [CHW-1:0]       sw_ch,
  input  logic                 wr_en,
  input  logic [CHW-1:0]       wr_ch,
  input  logic [1:0]           wr_sel,
  input  logic [AW-1:0]        wr_data,
  input  logic [CHW-1:0]       rd_ch,
  output logic [CNT_REG_W-1:0] rd_cur,
  output logic [NCH-1:0]       cfg_err,
  output logic [NCH-1:0]       start_req,
  output logic [NCH-1:0]       done_irq,
  output logic                 adj_valid,
  output logic [AW-1:0]        adj_addr,
  output logic                 sg_load
);
  logic [CNT_REG_W-1:0] cur_a [NCH];
  logic [CNT_REG_W-1:0] beg_a [NCH];
  logic [CTRL_W-1:0]    ctrl_a [NCH];
  logic [AW-1:0]        adj_a [NCH];

  logic                 act, upd_en, exhaust, mnr_vld, mjr_vld, irq, sg;
  logic [CNT_REG_W-1:0] upd_cur;
  logic [LNK_W-1:0]     mnr_ch, mjr_ch;
  logic [AW-1:0]        adj_next;

  for (genvar g = 0; g < NCH; g++) begin : g_slot
    dma_iter_slot #(.AW(AW)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en && (wr_ch == CHW'(g))),
      .wr_sel   (wr_sel),
      .wr_data  (wr_data),
      .upd_en   (upd_en && (minor_ch == CHW'(g))),
      .upd_cur  (upd_cur),
      .cur_o    (cur_a[g]),
      .beg_o    (beg_a[g]),
      .ctrl_o   (ctrl_a[g]),
      .adj_o    (adj_a[g]),
      .cfg_err_o(cfg_err[g])
    );
  end

  assign act    = minor_done && !cfg_err[minor_ch];
  assign rd_cur = cur_a[rd_ch];

  dma_iter_step #(.AW(AW)) u_step (
    .act     (act),
    .cur     (cur_a[minor_ch]),
    .beg     (beg_a[minor_ch]),
    .ctrl    (ctrl_a[minor_ch]),
    .adj     (adj_a[minor_ch]),
    .dst     (minor_dst),
    .upd_en  (upd_en),
    .upd_cur (upd_cur),
    .exhaust (exhaust),
    .mnr_vld (mnr_vld),
    .mnr_ch  (mnr_ch),
    .mjr_vld (mjr_vld),
    .mjr_ch  (mjr_ch),
    .irq     (irq),
    .sg      (sg),
    .adj_addr(adj_next)
  );

  dma_iter_out #(.NCH(NCH), .AW(AW)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_start  (sw_start),
    .sw_ch     (sw_ch),
    .mnr_vld   (mnr_vld),
    .mnr_ch    (mnr_ch),
    .mjr_vld   (mjr_vld),
    .mjr_ch    (mjr_ch),
    .exhaust   (exhaust),
    .irq       (irq),
    .irq_ch    (minor_ch),
    .sg        (sg),
    .adj_addr_d(adj_next),
    .start_req (start_req),
    .done_irq  (done_irq),
    .adj_valid (adj_valid),
    .adj_addr  (adj_addr),
    .sg_load   (sg_load)
  );
endmodule

// File: rtl/dma_iter_seq_chk.sv
module dma_iter_seq_chk #(
  parameter int NCH = 16,
  localparam int CHW = $clog2(NCH)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           minor_done,
  input logic [CHW-1:0] minor_ch,
  input logic           sw_start,
  input logic [CHW-1:0] sw_ch,
  input logic [NCH-1:0] cfg_err,
  input logic [NCH-1:0] start_req,
  input logic [NCH-1:0] done_irq,
  input logic           adj_valid,
  input logic           sg_load
);
  // R8
  cfg_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (minor_done && cfg_err[minor_ch]) |=> (!adj_valid && done_irq == '0));

  // R9
  sw_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_start |=> start_req[$past(sw_ch)]);

  // R9
  no_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!minor_done && !sw_start) |=> (start_req == '0));

  // R6
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(done_irq));

  // R7
  adj_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adj_valid |-> $past(minor_done));

  // R7
  sg_with_adj_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sg_load |-> adj_valid);

  // R6
  irq_with_adj_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_irq != '0) |-> adj_valid);
endmodule

bind dma_iter_seq dma_iter_seq_chk #(.NCH(NCH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .minor_done(minor_done),
  .minor_ch  (minor_ch),
  .sw_start  (sw_start),
  .sw_ch     (sw_ch),
  .cfg_err   (cfg_err),
  .start_req (start_req),
  .done_irq  (done_irq),
  .adj_valid (adj_valid),
  .sg_load   (sg_load)
);

// File: tb/test_dma_iter_seq.sv
`timescale 1ns/1ps
module test_dma_iter_seq;
  logic        clk, rst_n;
  logic        minor_done, sw_start, wr_en;
  logic [3:0]  minor_ch, sw_ch, wr_ch, rd_ch;
  logic [31:0] minor_dst, wr_data, adj_addr;
  logic [1:0]  wr_sel;
  logic [15:0] rd_cur, cfg_err, start_req, done_irq;
  logic        adj_valid, sg_load;
  int          n_run, n_fail;
  bit          wd_hit;

  dma_iter_seq i_dma_iter_seq (
    .clk(clk), .rst_n(rst_n), .minor_done(minor_done), .minor_ch(minor_ch),
    .minor_dst(minor_dst), .sw_start(sw_start), .sw_ch(sw_ch), .wr_en(wr_en),
    .wr_ch(wr_ch), .wr_sel(wr_sel), .wr_data(wr_data), .rd_ch(rd_ch),
    .rd_cur(rd_cur), .cfg_err(cfg_err), .start_req(start_req),
    .done_irq(done_irq), .adj_valid(adj_valid), .adj_addr(adj_addr),
    .sg_load(sg_load)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] ch, input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_ch = ch; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic slot(input logic [3:0] ch, input logic [15:0] cnt, input logic [7:0] ctl, input logic [31:0] adj);
    wr(ch, 2'd0, {16'd0, cnt});
    wr(ch, 2'd1, {16'd0, cnt});
    wr(ch, 2'd2, {24'd0, ctl});
    wr(ch, 2'd3, adj);
  endtask

  task automatic minor(input logic [3:0] ch, input logic [31:0] dst);
    @(negedge clk);
    minor_done = 1'b1; minor_ch = ch; minor_dst = dst;
    @(negedge clk);
    minor_done = 1'b0;
  endtask

  task automatic t_reset;
    rd_ch = 4'd9;
    chk(rd_cur == 16'h0, "R1 count", {16'd0, rd_cur}, 32'h0);
    chk(cfg_err == 16'hFFFF, "R1 cfg_err", {16'd0, cfg_err}, 32'hFFFF);
    chk(start_req == 0 && done_irq == 0 && !adj_valid && !sg_load, "R1 outputs",
        {start_req, done_irq}, 32'h0);
  endtask

  task automatic t_unlinked;
    slot(4'd2, 16'd3, 8'h01, 32'hFFFF_FFF0);
    rd_ch = 4'd2;
    chk(!cfg_err[2], "R8 valid slot", {31'd0, cfg_err[2]}, 32'h0);
    minor(4'd2, 32'h1000);
    chk(rd_cur == 16'd2, "R2 decrement", {16'd0, rd_cur}, 32'd2);
    chk(!adj_valid && done_irq == 0, "R6 no early irq", {15'd0, adj_valid, done_irq}, 32'h0);
    minor(4'd2, 32'h1000);
    chk(rd_cur == 16'd1, "R2 decrement 2", {16'd0, rd_cur}, 32'd1);
    minor(4'd2, 32'h1040);
    chk(adj_valid && adj_addr == 32'h1030 && !sg_load, "R7 adjust", adj_addr, 32'h1030);
    chk(done_irq == 16'h0004, "R6 irq", {16'd0, done_irq}, 32'h4);
    chk(rd_cur == 16'd3, "R4 reload", {16'd0, rd_cur}, 32'd3);
    @(negedge clk);
    chk(!adj_valid && done_irq == 0, "R6 pulse", {15'd0, adj_valid, done_irq}, 32'h0);
  endtask

  task automatic t_link;
    slot(4'd5, 16'h8E02, 8'h94, 32'h0);
    rd_ch = 4'd5;
    minor(4'd5, 32'h0);
    chk(start_req == 16'h0080, "R3 minor link", {16'd0, start_req}, 32'h80);
    chk(rd_cur == 16'h8E01, "R2 linked decrement", {16'd0, rd_cur}, 32'h8E01);
    minor(4'd5, 32'h0);
    chk(start_req == 16'h0200, "R4 R5 major link only", {16'd0, start_req}, 32'h200);
    chk(rd_cur == 16'h8E02 && done_irq == 0, "R4 R6 reload no irq", {done_irq, rd_cur}, 32'h8E02);
  endtask

  task automatic t_cfg;
    wr(4'd1, 2'd0, 32'h8E02);
    wr(4'd1, 2'd1, 32'h0002);
    wr(4'd1, 2'd2, 32'h05);
    rd_ch = 4'd1;
    chk(cfg_err[1], "R8 mismatch flag", {31'd0, cfg_err[1]}, 32'h1);
    minor(4'd1, 32'h0);
    chk(rd_cur == 16'h8E02 && start_req == 0 && !adj_valid && done_irq == 0,
        "R8 ignored", {start_req, rd_cur}, 32'h8E02);
    wr(4'd3, 2'd0, 32'h8000);
    wr(4'd3, 2'd1, 32'h8000);
    chk(cfg_err[3], "R8 zero count", {31'd0, cfg_err[3]}, 32'h1);
  endtask

  task automatic t_sg;
    slot(4'd4, 16'd1, 8'h02, 32'h2000_0100);
    rd_ch = 4'd4;
    for (int k = 0; k < 2; k++) begin
      minor(4'd4, 32'h55);
      chk(adj_valid && sg_load && adj_addr == 32'h2000_0100, "R7 scatter gather",
          adj_addr, 32'h2000_0100);
      chk(done_irq == 0 && rd_cur == 16'd1, "R6 R4 single request", {done_irq, rd_cur}, 32'h1);
    end
  endtask

  task automatic t_merge;
    slot(4'd6, 16'h8C02, 8'h00, 32'h0);
    @(negedge clk);
    minor_done = 1'b1; minor_ch = 4'd6; sw_start = 1'b1; sw_ch = 4'd6;
    @(negedge clk);
    minor_done = 1'b0; sw_start = 1'b0;
    chk(start_req == 16'h0040, "R9 merged self link", {16'd0, start_req}, 32'h40);
    @(negedge clk);
    sw_start = 1'b1; sw_ch = 4'd11;
    @(negedge clk);
    sw_start = 1'b0;
    chk(start_req == 16'h0800, "R9 software start", {16'd0, start_req}, 32'h800);
  endtask

  task automatic t_wr_prec;
    rd_ch = 4'd2;
    @(negedge clk);
    minor_done = 1'b1; minor_ch = 4'd2; minor_dst = 32'h0;
    wr_en = 1'b1; wr_ch = 4'd2; wr_sel = 2'd0; wr_data = 32'd10;
    @(negedge clk);
    minor_done = 1'b0; wr_en = 1'b0;
    chk(rd_cur == 16'd10, "R10 write wins", {16'd0, rd_cur}, 32'd10);
  endtask

  initial begin
    wd_hit = 1'b0;
    #100000;
    wd_hit = 1'b1;
  end

  initial begin
    n_run = 0; n_fail = 0;
    rst_n = 1'b0; minor_done = 1'b0; sw_start = 1'b0; wr_en = 1'b0;
    minor_ch = '0; sw_ch = '0; wr_ch = '0; rd_ch = '0; wr_sel = '0;
    wr_data = '0; minor_dst = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    fork
      begin
        t_reset;
        t_unlinked;
        t_link;
        t_cfg;
        t_sg;
        t_merge;
        t_wr_prec;
      end
      begin
        wait (wd_hit);
        chk(1'b0, "watchdog", 32'h0, 32'h1);
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule